// File: doc/BRIEF.md
# Serial port status flag register

This block is the 8-bit status register of an asynchronous serial port, seen by the processor over a simple register bus. It keeps five sticky flags: transmit buffer empty, receive buffer full, overrun, framing error and parity error. It also keeps a transmit-complete bit, the multiprocessor bit captured with the last received character, and a processor-written multiprocessor bit for the next outgoing character. The transmit and receive datapaths report their events as single-cycle strobes. The register returns the flags as levels on the read-data port.

Software cannot set a sticky flag. It clears a flag by writing 0 to it, and such a write takes effect only after a read has returned that flag as 1, with no new hardware event on that flag since the read. A read arms the flags it sees set. A hardware set of a flag disarms that flag. A hardware set that lands in the same cycle as a software clear takes priority, so no event is lost. The transmit-empty flag has more sources. It is forced to 1 while the transmitter is disabled, set to 1 when the buffered byte moves into the shifter, and cleared when software writes a new byte into the transmit buffer.

Top module: `ser_stat_reg`

## Requirements
- R1: Read-data bit positions, from bit 7 down to bit 0: transmit empty, receive full, overrun, framing error, parity error, transmit end, received multiprocessor bit, transmit multiprocessor bit.
- R2: An asynchronous reset or a one-cycle `standby_i` pulse sets the register to 0x84 and disarms every flag. A write of 0 that follows without a new read clears nothing.
- R3: Writing 1 to any of the five sticky flags (bits 7..3) leaves that flag unchanged.
- R4: A write of 0 to a sticky flag clears it on the next edge only if an earlier read returned it as 1 and no hardware set of that flag has occurred since that read. Otherwise the flag stays 1.
- R5: Writes do not change bits 2 and 1. Bit 0 takes the written value on every register write.
- R6: When a hardware set of a sticky flag falls in the same cycle as a clear of that flag (a software write of 0, or a transmit-buffer write for bit 7), the flag is 1 after that edge.
- R7: Bit 7 is 1 after any cycle in which `tx_en_i` is 0 or `tx_load_i` is 1.
- R8: A `tdr_wr_i` pulse with `tx_en_i`=1 and no `tx_load_i` clears bit 7 on the next edge.
- R9: `rx_done_i` sets bit 6 and loads `rx_mpb_i` into bit 1. `rx_ovr_i`, `rx_ferr_i` and `rx_perr_i` set bits 5, 4 and 3.
- R10: Bit 2 becomes 1 after a cycle with `tx_idle_i`=1 while bit 7 is 1, and becomes 0 after a cycle with `tx_load_i`=1. `tx_load_i` wins if both conditions hold.
- R11: A read and a write in the same cycle: the write is qualified only by reads from earlier cycles. The read still arms the flags for later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| standby_i | input | 1 | Standby entry pulse; reinitialises the register |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Current register value |
| tdr_wr_i | input | 1 | Processor write to the transmit data buffer |
| tx_en_i | input | 1 | Transmitter enable level |
| tx_load_i | input | 1 | Buffer-to-shifter load strobe |
| tx_idle_i | input | 1 | Transmit shifter idle level |
| rx_done_i | input | 1 | Character received strobe |
| rx_mpb_i | input | 1 | Multiprocessor bit of the received character |
| rx_ovr_i | input | 1 | Receive overrun strobe |
| rx_ferr_i | input | 1 | Framing error strobe |
| rx_perr_i | input | 1 | Parity error strobe |

## Verification
The bound checker checks every cycle that written 1s never raise a sticky flag, that a flag which has just risen survives an immediate write of 0, that read-only bits hold through writes, that hardware strobes win over clears, and that the transmit-empty and transmit-end paths react one edge after their strobes. Some behaviours depend on history that a short property cannot follow: disarming of the read qualification by standby, loss of arming after a later hardware event, and the ordering of a read and a write in the same cycle. Only the bench's sequences show those.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_STICKY = 5;
  localparam int STICKY_LSB = 3;
  // bit positions (R1)
  localparam int B_TXE   = 7;
  localparam int B_RXF   = 6;
  localparam int B_OVR   = 5;
  localparam int B_FRM   = 4;
  localparam int B_PAR   = 3;
  localparam int B_TXEND = 2;
  localparam int B_MPR   = 1;
  localparam int B_MPT   = 0;
  localparam logic [REG_W-1:0] INIT_VAL = 8'h84;
  // sticky slot index of the transmit-empty flag
  localparam int S_TXE = B_TXE - STICKY_LSB;
endpackage

// File: rtl/ssr_rst_sync.sv
module ssr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/ssr_sticky_flag.sv
module ssr_sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic sw_clr, en;

  // only a write of 0 against an armed flag clears it (R4); a 1 does nothing (R3)
  always_comb begin
    sw_clr = wr_i & ~wbit_i & arm_q;
    en     = init_i | set_i | hw_clr_i | sw_clr | rd_i;
    if (init_i) begin
      flag_d = RST_VAL;
      arm_d  = 1'b0;
    end else if (set_i) begin        // set wins and disarms (R6)
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (hw_clr_i | sw_clr) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else begin                   // a read arms on the value it saw (R11)
      flag_d = flag_q;
      arm_d  = arm_q | (rd_i & flag_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else if (en) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ssr_aux_bits.sv
module ssr_aux_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic txe_i,
  input  logic tx_load_i,
  input  logic tx_idle_i,
  input  logic rx_done_i,
  input  logic rx_mpb_i,
  input  logic wr_i,
  input  logic wbit0_i,
  output logic tend_o,
  output logic mpb_o,
  output logic mpbt_o
);
  logic tend_q, tend_d, tend_en;
  logic mpb_q, mpb_d, mpb_en;
  logic mpbt_q, mpbt_d, mpbt_en;

  always_comb begin
    // transmit end: load clears, idle with empty buffer sets (R10)
    tend_en = init_i | tx_load_i | (tx_idle_i & txe_i);
    tend_d  = init_i | ~tx_load_i;
    // received multiprocessor bit, not writable (R5, R9)
    mpb_en  = init_i | rx_done_i;
    mpb_d   = ~init_i & rx_mpb_i;
    // outgoing multiprocessor bit, plain read/write (R5)
    mpbt_en = init_i | wr_i;
    mpbt_d  = ~init_i & wbit0_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
      mpb_q  <= 1'b0;
      mpbt_q <= 1'b0;
    end else begin
      if (tend_en) tend_q <= tend_d;
      if (mpb_en)  mpb_q  <= mpb_d;
      if (mpbt_en) mpbt_q <= mpbt_d;
    end
  end

  assign tend_o = tend_q;
  assign mpb_o  = mpb_q;
  assign mpbt_o = mpbt_q;
endmodule

// File: rtl/ser_stat_reg.sv
module ser_stat_reg
  import ssr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             tdr_wr_i,
  input  logic             tx_en_i,
  input  logic             tx_load_i,
  input  logic             tx_idle_i,
  input  logic             rx_done_i,
  input  logic             rx_mpb_i,
  input  logic             rx_ovr_i,
  input  logic             rx_ferr_i,
  input  logic             rx_perr_i
);
  logic                  rst_q_n;
  logic [NUM_STICKY-1:0] set_vec;
  logic [NUM_STICKY-1:0] hw_clr_vec;
  logic [NUM_STICKY-1:0] flag_vec;
  logic                  tend, mpb, mpbt;
  logic                  unused_wbits;

  ssr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // hardware event sources per sticky slot (slot i is register bit STICKY_LSB+i)
  always_comb begin
    set_vec    = '0;
    hw_clr_vec = '0;
    set_vec[B_TXE - STICKY_LSB] = ~tx_en_i | tx_load_i;   // R7
    hw_clr_vec[S_TXE]           = tdr_wr_i;               // R8
    set_vec[B_RXF - STICKY_LSB] = rx_done_i;              // R9
    set_vec[B_OVR - STICKY_LSB] = rx_ovr_i;
    set_vec[B_FRM - STICKY_LSB] = rx_ferr_i;
    set_vec[B_PAR - STICKY_LSB] = rx_perr_i;
  end

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    ssr_sticky_flag #(
      .RST_VAL (INIT_VAL[STICKY_LSB + i])
    ) u_flag (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .init_i   (standby_i),
      .set_i    (set_vec[i]),
      .hw_clr_i (hw_clr_vec[i]),
      .rd_i     (reg_rd_i),
      .wr_i     (reg_wr_i),
      .wbit_i   (reg_wdata_i[STICKY_LSB + i]),
      .flag_o   (flag_vec[i])
    );
  end

  ssr_aux_bits u_aux (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .init_i    (standby_i),
    .txe_i     (flag_vec[S_TXE]),
    .tx_load_i (tx_load_i),
    .tx_idle_i (tx_idle_i),
    .rx_done_i (rx_done_i),
    .rx_mpb_i  (rx_mpb_i),
    .wr_i      (reg_wr_i),
    .wbit0_i   (reg_wdata_i[B_MPT]),
    .tend_o    (tend),
    .mpb_o     (mpb),
    .mpbt_o    (mpbt)
  );

  // write data for the read-only bits is discarded (R5)
  assign unused_wbits = &{1'b0, reg_wdata_i[B_TXEND:B_MPR]};

  // R1 layout
  always_comb begin
    reg_rdata_o                           = '0;
    reg_rdata_o[B_TXE:STICKY_LSB]         = flag_vec;
    reg_rdata_o[B_TXEND]                  = tend;
    reg_rdata_o[B_MPR]                    = mpb;
    reg_rdata_o[B_MPT]                    = mpbt;
  end
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic       standby_i,
  input logic       reg_rd_i,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       tdr_wr_i,
  input logic       tx_en_i,
  input logic       tx_load_i,
  input logic       tx_idle_i,
  input logic       rx_done_i,
  input logic       rx_ovr_i
);
  a_r2_standby_init: assert property (@(posedge clk) disable iff (!rst_q_n)
    standby_i |=> (reg_rdata_o == 8'h84));

  a_r3_no_sw_set: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr_i && reg_wdata_i[6] && !rx_done_i && !standby_i && !reg_rdata_o[6])
      |=> !reg_rdata_o[6]);

  a_r4_needs_prior_read: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($rose(reg_rdata_o[5]) && reg_wr_i && !reg_wdata_i[5] && !standby_i)
      |=> reg_rdata_o[5]);

  a_r5_mpb_readonly: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr_i && !rx_done_i && !standby_i) |=> $stable(reg_rdata_o[1]));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rx_ovr_i && reg_wr_i && !reg_wdata_i[5]) |=> reg_rdata_o[5]);

  a_r7_txen_low: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!tx_en_i || tx_load_i) |=> reg_rdata_o[7]);

  a_r8_tdr_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tdr_wr_i && tx_en_i && !tx_load_i && !standby_i) |=> !reg_rdata_o[7]);

  a_r9_rx_full: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_done_i |=> reg_rdata_o[6]);

  a_r10_tend_clr: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tx_load_i && !standby_i) |=> !reg_rdata_o[2]);

  a_r10_tend_set: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tx_idle_i && reg_rdata_o[7] && !tx_load_i) |=> reg_rdata_o[2]);

  // R11: a read alone never changes the register
  a_r11_read_passive: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_rd_i && !reg_wr_i && !standby_i && !tdr_wr_i && tx_en_i && !tx_load_i
     && !tx_idle_i && !rx_done_i && !rx_ovr_i) |=> $stable(reg_rdata_o[7:5]));
endmodule

bind ser_stat_reg ssr_chk u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .standby_i   (standby_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .tdr_wr_i    (tdr_wr_i),
  .tx_en_i     (tx_en_i),
  .tx_load_i   (tx_load_i),
  .tx_idle_i   (tx_idle_i),
  .rx_done_i   (rx_done_i),
  .rx_ovr_i    (rx_ovr_i)
);

// File: tb/sim_ser_stat_reg.sv
`timescale 1ns/1ps
module sim_ser_stat_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       standby_i, reg_rd_i, reg_wr_i;
  logic [7:0] reg_wdata_i, reg_rdata_o;
  logic       tdr_wr_i, tx_en_i, tx_load_i, tx_idle_i;
  logic       rx_done_i, rx_mpb_i, rx_ovr_i, rx_ferr_i, rx_perr_i;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ser_stat_reg u0 (.*);

  // {rd, wr, wdata[8], tdr_wr, tx_en, load, idle, rx_done, mpb, ovr, ferr, perr, expected[8]}
  localparam int NV = 16;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h84}, // R2 idle
    {1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h04}, // R8
    {1'b0,1'b0,8'h00, 1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80}, // R7 R10
    {1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h84}, // R10
    {1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'hC6}, // R9 R1
    {1'b0,1'b1,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC6}, // R4 no read
    {1'b1,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC6}, // R4 read
    {1'b0,1'b1,8'hFF, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC7}, // R3 R5
    {1'b0,1'b1,8'h80, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h86}, // R4 R5
    {1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,1'b1, 8'hBE}, // R9
    {1'b1,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'hBE}, // R11 read
    {1'b0,1'b1,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'h26}, // R6
    {1'b0,1'b1,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h26}, // R4 disarmed
    {1'b1,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h26}, // R4 read
    {1'b0,1'b1,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h06}, // R4 clear
    {1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h86}  // R7 tx off
  };
  localparam int VREQ [NV] = '{2,8,7,10,9,4,4,3,4,9,11,6,4,4,4,7};

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic clear_pulses();
    standby_i = 0; reg_rd_i = 0; reg_wr_i = 0; reg_wdata_i = 8'h00;
    tdr_wr_i = 0; tx_load_i = 0; tx_idle_i = 0;
    rx_done_i = 0; rx_mpb_i = 0; rx_ovr_i = 0; rx_ferr_i = 0; rx_perr_i = 0;
  endtask

  // one cycle of stimulus, driven just after a falling edge, result read one edge later
  task automatic step();
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic do_wr(input logic [7:0] d);
    reg_wr_i = 1; reg_wdata_i = d; step();
  endtask

  task automatic do_rd();
    reg_rd_i = 1; step();
  endtask

  initial begin
    clear_pulses();
    tx_en_i = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R2 async reset value", reg_rdata_o, 8'h84);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R2 after reset release", reg_rdata_o, 8'h84);

    for (int i = 0; i < NV; i++) begin
      reg_rd_i    = VEC[i][26];
      reg_wr_i    = VEC[i][25];
      reg_wdata_i = VEC[i][24:17];
      tdr_wr_i    = VEC[i][16];
      tx_en_i     = VEC[i][15];
      tx_load_i   = VEC[i][14];
      tx_idle_i   = VEC[i][13];
      rx_done_i   = VEC[i][12];
      rx_mpb_i    = VEC[i][11];
      rx_ovr_i    = VEC[i][10];
      rx_ferr_i   = VEC[i][9];
      rx_perr_i   = VEC[i][8];
      step();
      check($sformatf("R%0d vector %0d", VREQ[i], i), reg_rdata_o, VEC[i][7:0]);
    end
    tx_en_i = 1;

    // R2: standby reinitialises and disarms a previously read flag
    tdr_wr_i = 1; step();
    check("R8 buffer write", reg_rdata_o, 8'h06);
    tx_load_i = 1; step();
    check("R10 load clears end", reg_rdata_o, 8'h82);
    do_rd();
    standby_i = 1; step();
    check("R2 standby value", reg_rdata_o, 8'h84);
    do_wr(8'h00);
    check("R2 standby disarms", reg_rdata_o, 8'h84);

    // R11: read and write in the same cycle
    rx_done_i = 1; rx_mpb_i = 0; step();
    check("R9 rx full, mpb 0", reg_rdata_o, 8'hC4);
    reg_rd_i = 1; do_wr(8'h00);
    check("R11 same-cycle read not used", reg_rdata_o, 8'hC4);
    do_wr(8'h00);
    check("R11 read armed later write", reg_rdata_o, 8'h04);

    // R4: event after the read disarms
    rx_done_i = 1; step();
    do_rd();
    rx_done_i = 1; step();
    do_wr(8'h00);
    check("R4 later event keeps flag", reg_rdata_o, 8'h44);

    // R6: buffer write and load in the same cycle
    tdr_wr_i = 1; tx_load_i = 1; step();
    check("R6 load beats buffer write", reg_rdata_o, 8'hC0);

    // R5: bit 0 written, others untouched
    do_wr(8'h01);
    check("R5 mpbt write", reg_rdata_o, 8'hC1);

    // R2 reset mid-run
    rst_n = 0; #1;
    check("R2 reset mid-run", reg_rdata_o, 8'h84);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule